// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Aggregator

This block merges a set of interrupt condition inputs into one interrupt output. Each source has an enable bit and a two-bit trigger code. The code makes the source fire when its condition arrives, when the condition goes away, or for as long as the condition lasts. The upper and lower bits of every source's code sit in two separate configuration registers, at the same bit position in each.

A small register port sits beside the block: a write strobe, an address and write data, with read data taken combinationally from the address. Through it software reaches the enable mask, the two trigger-code registers, a two-bit output-polarity field and a status register. A read of the status register clears it. An edge-triggered status bit stays set until such a read clears it. A level-triggered bit shows the live condition, so a read cannot clear it. The output pin is driven from the OR of the enabled status bits, and its active sense comes only from the polarity field.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the mask, both trigger-code registers, the polarity field and the status register read as zero. The output then reads irq_o = 0 with irq_oe = 1.
- R2: A source whose mask bit is 0 sets no status bit and cannot drive the output. A mask bit of 1 enables that source. Mask bit i belongs to status bit i.
- R3: Source i takes its trigger code from bit i of the high-code register (address 1) and bit i of the low-code register (address 2), as {high, low}.
- R4: Code 00 (rising): a 0-to-1 change on cond_i[i] sets status bit i. The bit is visible two clock edges after the input changes and stays set until a status read.
- R5: Code 01 (falling): a 1-to-0 change on cond_i[i] sets status bit i. It has the same timing and holding behaviour as R4.
- R6: Code 10 (level): status bit i equals the condition one edge after the input changes. A status read does not clear it while the condition stays high.
- R7: Code 11 is reserved. That source never sets its status bit.
- R8: Reading address 4 returns the status, and the clock edge of that read clears every edge-latched bit. An edge detected in the same cycle as the read is latched and kept.
- R9: The polarity field is bits [1:0] of address 3. With the output asserted, codes 00 and 11 give irq_o = 1 and irq_oe = 1. Code 01 gives irq_o = 0 and irq_oe = 1. Code 10 gives irq_o = 0 and irq_oe = 1. With the output deasserted, codes 00, 01 and 11 give irq_o = 0, 1 and 0 with irq_oe = 1. Code 10 gives irq_oe = 0.
- R10: Addresses 0 to 3 read back the last written values. Address 3 returns only bits [1:0], and unused addresses read as zero.
- R11: The output is asserted exactly when at least one status bit with its mask bit set is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | N_SRC | Interrupt condition inputs, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears status when addr is 4 |
| addr | input | 3 | Register address |
| wdata | input | N_SRC | Write data |
| rdata | output | N_SRC | Read data for addr (combinational) |
| irq_o | output | 1 | Interrupt output level |
| irq_oe | output | 1 | Interrupt output drive enable |

## Verification
The assertions assume that cond_i is synchronous to clk and holds for at least one edge. They also assume the configuration does not change in the same cycle as a condition edge, because latching is judged against the mask and codes sampled with that edge. The stimulus drives every input on the falling clock edge. It writes the configuration only while the conditions are steady, and it changes conditions only after the registers have settled. A read-clear is deliberately placed in the cycle of a fresh edge, so the assertions see the overlap of clearing and latching.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_RSVD  = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        POL_HIGH     = 2'b00,
        POL_LOW      = 2'b01,
        POL_OD_LOW   = 2'b10,
        POL_HIGH_ALT = 2'b11
    } pol_e;

    localparam logic [ADDR_W-1:0] ADDR_MASK    = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CODE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CODE_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_POL     = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_STAT    = 3'd4;

    typedef struct packed {
        logic level;
        logic drive_en;
    } pin_t;

    function automatic trig_e trig_of(input logic hi, input logic lo);
        return trig_e'({hi, lo});
    endfunction

    function automatic pin_t drive_pin(input pol_e pol, input logic active);
        pin_t p;
        case (pol)
            POL_LOW:    begin p.level = ~active; p.drive_en = 1'b1;   end
            POL_OD_LOW: begin p.level = 1'b0;    p.drive_en = active; end
            default:    begin p.level = active;  p.drive_en = 1'b1;   end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [N_SRC-1:0]    wdata,
    output logic [N_SRC-1:0]    mask_o,
    output logic [N_SRC-1:0]    code_hi_o,
    output logic [N_SRC-1:0]    code_lo_o,
    output pol_e                pol_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o    <= '0;
            code_hi_o <= '0;
            code_lo_o <= '0;
            pol_o     <= POL_HIGH;
        end else if (wr_en) begin
            case (addr)
                ADDR_MASK:    mask_o    <= wdata;
                ADDR_CODE_HI: code_hi_o <= wdata;
                ADDR_CODE_LO: code_lo_o <= wdata;
                ADDR_POL:     pol_o     <= pol_e'(wdata[1:0]);
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] cond_i,
    input  logic [N_SRC-1:0] mask_i,
    input  logic [N_SRC-1:0] code_hi_i,
    input  logic [N_SRC-1:0] code_lo_i,
    output logic [N_SRC-1:0] cur_o,
    output logic [N_SRC-1:0] prev_o,
    output logic [N_SRC-1:0] evt_o,
    output logic [N_SRC-1:0] level_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_o  <= '0;
            prev_o <= '0;
        end else begin
            cur_o  <= cond_i;
            prev_o <= cur_o;
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        trig_e mode_w;
        logic  raw_w;
        assign mode_w = trig_of(code_hi_i[i], code_lo_i[i]);

        always_comb begin
            case (mode_w)
                TRIG_RISE: raw_w = cur_o[i] & ~prev_o[i];
                TRIG_FALL: raw_w = ~cur_o[i] & prev_o[i];
                default:   raw_w = 1'b0;
            endcase
        end

        assign evt_o[i]   = raw_w & mask_i[i];
        assign level_o[i] = (mode_w == TRIG_LEVEL) & cur_o[i] & mask_i[i];
    end

endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_i,
    input  logic [N_SRC-1:0] level_i,
    output logic [N_SRC-1:0] latched_o,
    output logic [N_SRC-1:0] status_o
);

    logic [N_SRC-1:0] keep_w;

    assign keep_w = clr_i ? '0 : latched_o;

    always_ff @(posedge clk) begin
        if (rst) latched_o <= '0;
        else     latched_o <= keep_w | evt_i;
    end

    assign status_o = latched_o | level_i;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  cond_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]  wdata,
    output logic [N_SRC-1:0]  rdata,
    output logic              irq_o,
    output logic              irq_oe
);

    logic [N_SRC-1:0] mask_q, code_hi_q, code_lo_q;
    pol_e             pol_q;
    logic [N_SRC-1:0] cond_cur, cond_prev, evt_w, level_w;
    logic [N_SRC-1:0] latched_q, status_w;
    logic             stat_clr, active_w;
    pin_t             pin_w;

    irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mask_o(mask_q), .code_hi_o(code_hi_q), .code_lo_o(code_lo_q), .pol_o(pol_q)
    );

    irq_edge_detect #(.N_SRC(N_SRC)) u_det (
        .clk(clk), .rst(rst), .cond_i(cond_i), .mask_i(mask_q),
        .code_hi_i(code_hi_q), .code_lo_i(code_lo_q),
        .cur_o(cond_cur), .prev_o(cond_prev), .evt_o(evt_w), .level_o(level_w)
    );

    assign stat_clr = rd_en && (addr == ADDR_STAT);

    irq_status_latch #(.N_SRC(N_SRC)) u_stat (
        .clk(clk), .rst(rst), .evt_i(evt_w), .clr_i(stat_clr),
        .level_i(level_w), .latched_o(latched_q), .status_o(status_w)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_MASK:    rdata = mask_q;
            ADDR_CODE_HI: rdata = code_hi_q;
            ADDR_CODE_LO: rdata = code_lo_q;
            ADDR_POL:     rdata[1:0] = pol_q;
            ADDR_STAT:    rdata = status_w;
            default:      rdata = '0;
        endcase
    end

    assign active_w = |(status_w & mask_q);
    assign pin_w    = drive_pin(pol_q, active_w);
    assign irq_o    = pin_w.level;
    assign irq_oe   = pin_w.drive_en;

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] cond_cur,
    input logic [N_SRC-1:0] cond_prev,
    input logic [N_SRC-1:0] mask_q,
    input logic [N_SRC-1:0] code_hi_q,
    input logic [N_SRC-1:0] code_lo_q,
    input logic [N_SRC-1:0] latched_q,
    input logic [N_SRC-1:0] status_w,
    input logic             stat_clr,
    input logic [1:0]       pol_q,
    input logic             irq_o,
    input logic             irq_oe
);

    logic [N_SRC-1:0] rise_ev, fall_ev;
    assign rise_ev = ~code_hi_q & ~code_lo_q & cond_cur & ~cond_prev & mask_q;
    assign fall_ev = ~code_hi_q &  code_lo_q & ~cond_cur & cond_prev & mask_q;

    p_rise_latch_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latched_q & $past(rise_ev)) == $past(rise_ev)));

    p_fall_latch_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latched_q & $past(fall_ev)) == $past(fall_ev)));

    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latched_q & ~$past(latched_q) & ~$past(mask_q)) == '0));

    p_no_stray_latch_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latched_q & ~$past(latched_q) & ~$past(rise_ev | fall_ev)) == '0));

    p_hold_until_read_r8: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> ((latched_q & $past(latched_q)) == $past(latched_q)));

    p_drive_enable_r9: assert property (@(posedge clk) disable iff (rst)
        (pol_q != 2'b10) |-> irq_oe);

    p_idle_output_r11: assert property (@(posedge clk) disable iff (rst)
        ((status_w & mask_q) == '0) |->
            ((pol_q == 2'b01) ? irq_o : ((pol_q == 2'b10) ? !irq_oe : !irq_o)));

endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst(rst), .cond_cur(cond_cur), .cond_prev(cond_prev),
    .mask_q(mask_q), .code_hi_q(code_hi_q), .code_lo_q(code_lo_q),
    .latched_q(latched_q), .status_w(status_w), .stat_clr(stat_clr),
    .pol_q(pol_q), .irq_o(irq_o), .irq_oe(irq_oe)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int NVEC = 6;
    // {cond pattern, expected status}; mask FF, hi F0, lo CC:
    // bits 1:0 rise, 3:2 fall, 5:4 level, 7:6 reserved
    localparam logic [15:0] VEC [NVEC] = '{
        16'hFF33, 16'h000C, 16'h5511, 16'hAA26, 16'hAA20, 16'h0F01
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] cond_i = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq_o, irq_oe;

    int n_run = 0;
    int n_fail = 0;
    logic [N-1:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator #(.N_SRC(N)) u_irq_aggregator (
        .clk(clk), .rst(rst), .cond_i(cond_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [N-1:0] d);
        @(negedge clk); rd_en = 1'b0; addr = a; #1 d = rdata;
    endtask

    task automatic read_clear(output logic [N-1:0] d);
        @(negedge clk); rd_en = 1'b1; addr = 3'd4; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_cond(input logic [N-1:0] c);
        @(negedge clk); cond_i = c;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            peek(3'(a), v);
            check("R1 reg reset", v, '0);
        end
        check("R1 irq_o", {7'd0, irq_o}, 8'h00);
        check("R1 irq_oe", {7'd0, irq_oe}, 8'h01);

        // R10: readback
        wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h96); wr(3'd3, 8'hFE);
        peek(3'd0, v); check("R10 mask", v, 8'hA5);
        peek(3'd1, v); check("R10 code hi", v, 8'h3C);
        peek(3'd2, v); check("R10 code lo", v, 8'h96);
        peek(3'd3, v); check("R10 polarity", v, 8'h02);
        peek(3'd6, v); check("R10 unused", v, 8'h00);

        // R3..R7, R11: vector walk
        wr(3'd3, 8'h00); wr(3'd0, 8'hFF); wr(3'd1, 8'hF0); wr(3'd2, 8'hCC);
        for (int k = 0; k < NVEC; k++) begin
            set_cond(VEC[k][15:8]);
            repeat (2) @(posedge clk);
            peek(3'd4, v);
            check("R3/R4/R5/R6/R7 status", v, VEC[k][7:0]);
            check("R11 irq", {7'd0, irq_o}, {7'd0, (VEC[k][7:0] != 0)});
            read_clear(v);
        end

        // R2: masked source stays silent
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        set_cond(8'h00); repeat (2) @(posedge clk); read_clear(v);
        wr(3'd0, 8'hFE);
        set_cond(8'h01); repeat (2) @(posedge clk);
        peek(3'd4, v); check("R2 masked status", v, 8'h00);
        check("R2 masked irq", {7'd0, irq_o}, 8'h00);
        wr(3'd0, 8'hFF);
        set_cond(8'h03); repeat (2) @(posedge clk);
        peek(3'd4, v); check("R2 enabled status", v, 8'h02);

        // R8: edge in the same cycle as the clearing read is kept
        set_cond(8'h07);
        read_clear(v); check("R8 read value", v, 8'h02);
        peek(3'd4, v); check("R8 kept edge", v, 8'h04);

        // R9: polarity, asserted then deasserted
        wr(3'd3, 8'h01); check("R9 low asserted", {6'd0, irq_o, irq_oe}, 8'h01);
        wr(3'd3, 8'h02); check("R9 od asserted", {6'd0, irq_o, irq_oe}, 8'h01);
        wr(3'd3, 8'h03); check("R9 alt asserted", {6'd0, irq_o, irq_oe}, 8'h03);
        read_clear(v);
        peek(3'd4, v); check("R8 cleared", v, 8'h00);
        check("R9 alt idle", {6'd0, irq_o, irq_oe}, 8'h01);
        wr(3'd3, 8'h01); check("R9 low idle", {6'd0, irq_o, irq_oe}, 8'h03);
        wr(3'd3, 8'h02); check("R9 od idle", {6'd0, irq_o, irq_oe}, 8'h00);
        wr(3'd3, 8'h00);

        // R6: level bit survives a clearing read and follows the input
        wr(3'd1, 8'h08);
        set_cond(8'h0F); repeat (2) @(posedge clk);
        read_clear(v); check("R6 level read", v, 8'h08);
        peek(3'd4, v); check("R6 not cleared", v, 8'h08);
        set_cond(8'h07); @(posedge clk);
        peek(3'd4, v); check("R6 follows drop", v, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule